// File: doc/BRIEF.md
# PWM Action Qualifier with Software Force

This block turns time-base events into two PWM output levels, A and B. On each time-base tick it sees the counter value, the count direction and the zero-match and period-match strobes. It also compares the counter against two 16-bit compare registers while counting up. Each output has its own action register with a 2-bit code for every event. The code says whether that event leaves the output alone, drives it low, drives it high or toggles it. When several events land on the same tick, a fixed priority picks the one that acts.

A continuous software force can override each output. Software writes the force codes into a shadow register. A selectable reload point (counter zero, period, either, or the next tick) copies the shadow into the active force. While an active force is in effect, it sets the level of its output and masks every event action. A simple write port loads the compare, action, force-shadow and reload-mode registers. Outputs change only on clock cycles where the tick input is high, and they are registered.

Top module: `pwm_aq`

## Requirements
- R1: Synchronous reset drives both outputs low and clears all compare, action, force-shadow, active-force and reload-mode state. After reset, events on a tick leave the outputs low.
- R2: An output changes only on a clock edge where `tick` is high. Events presented without `tick` have no effect.
- R3: Action register fields are zero event bits 1:0, period event bits 3:2, compare-A-up bits 5:4 and compare-B-up bits 9:8. Codes: 00 no action, 01 low, 10 high, 11 toggle the present level.
- R4: A compare event happens only on a tick with `cnt_up` high and `cnt` equal to the compare register. Output A uses its action register, output B uses its own. With `cnt_up` low an equal counter causes no compare action.
- R5: When several events with a code other than 00 occur on one tick, exactly one applies: compare B first, then compare A, then period, then zero. An event coded 00 does not block a lower one.
- R6: Force codes sit in bits 1:0 (output A) and 3:2 (output B) of the force-shadow register. Active code 01 holds the output low and 10 holds it high, overriding all event actions. 00 and 11 mean no force.
- R7: Reload-mode bits 7:6 of their register select when the shadow is copied to the active force: 00 on a tick with zero, 01 on a tick with period, 10 on a tick with either, 11 on any tick. The copied force governs the level on that same tick.
- R8: Writing the force shadow does not change an output until a reload point has been reached.
- R9: Action value 0x01A gives normal polarity: high from the zero event until compare A while counting up. 0x205 on output B gives inverted polarity: low from zero, high at compare B.
- R10: Write addresses: 0 compare A, 1 compare B, 2 action A, 3 action B, 4 force shadow, 5 reload mode. A write is seen by ticks in later cycles.
- R11: When a reload clears an active force, the event actions of that same tick apply to the held level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base tick qualifier |
| cnt | input | CNT_W | Time-base counter value |
| cnt_up | input | 1 | High when the counter is counting up |
| zero_evt | input | 1 | Counter equals zero strobe |
| prd_evt | input | 1 | Counter equals period strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| pwm_a | output | 1 | Output A level (registered) |
| pwm_b | output | 1 | Output B level (registered) |

## Verification
A force reload and an event action can fall on the same tick. This happens when the reload point is the zero or period event, which may also carry an action of its own. The bench provokes this by trying every shadow code under every reload mode while the counter passes zero, compare and period ticks. A reference model loads the shadow first, then lets an active force override the resolved action (or lets the action act on the held level when the force clears). Coincident events are covered the same way: every action-code combination is swept with compare registers that are separate or equal, and with the zero and period strobes in all combinations.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  localparam int ADDR_W = 3;
  localparam int NUM_CH = 2;

  // Write-port register addresses
  localparam logic [ADDR_W-1:0] ADR_CMP_A = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CMP_B = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_ACT_A = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_ACT_B = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_FRC   = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_RLD   = 3'd5;

  // Field offsets inside action and reload-mode words
  localparam int FLD_ZRO = 0;
  localparam int FLD_PRD = 2;
  localparam int FLD_CAU = 4;
  localparam int FLD_CBU = 8;
  localparam int FLD_RLD = 6;
  localparam int ACT_MSB = FLD_CBU + 1;

  typedef enum logic [1:0] {ACT_NONE, ACT_LOW, ACT_HIGH, ACT_TOG} act_e;
  typedef enum logic [1:0] {RLD_ZERO, RLD_PRD, RLD_EITHER, RLD_NOW} rld_e;
  typedef enum logic [1:0] {FRC_OFF, FRC_LOW, FRC_HIGH, FRC_OFF_ALT} frc_e;

  typedef struct packed {
    act_e cb;
    act_e ca;
    act_e prd;
    act_e zro;
  } act_set_t;
endpackage

// File: rtl/pwm_aq_regs.sv
module pwm_aq_regs
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [NUM_CH-1:0][CNT_W-1:0]   cmp_o,
  output act_set_t [NUM_CH-1:0]          act_o,
  output logic [NUM_CH-1:0][1:0]         frc_sh_o,
  output rld_e                           rld_o
);
  logic unused_data;
  assign unused_data = ^wr_data;

  function automatic act_set_t decode_act(input logic [DATA_W-1:0] w);
    act_set_t r;
    r.zro = act_e'(w[FLD_ZRO +: 2]);
    r.prd = act_e'(w[FLD_PRD +: 2]);
    r.ca  = act_e'(w[FLD_CAU +: 2]);
    r.cb  = act_e'(w[FLD_CBU +: 2]);
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_o    <= '0;
      act_o    <= '0;
      frc_sh_o <= '0;
      rld_o    <= RLD_ZERO;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CMP_A: cmp_o[0]  <= wr_data[CNT_W-1:0];
        ADR_CMP_B: cmp_o[1]  <= wr_data[CNT_W-1:0];
        ADR_ACT_A: act_o[0]  <= decode_act(wr_data);
        ADR_ACT_B: act_o[1]  <= decode_act(wr_data);
        ADR_FRC:   frc_sh_o  <= wr_data[2*NUM_CH-1:0];
        ADR_RLD:   rld_o     <= rld_e'(wr_data[FLD_RLD +: 2]);
        default: ;
      endcase
    end
  end

  // R10: a compare write is visible on the next cycle
  p_cmp_write_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADR_CMP_A) |=> (cmp_o[0] == $past(wr_data[CNT_W-1:0])));

  // R1: reset clears the reload mode
  p_rld_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rld_o == RLD_ZERO && frc_sh_o == '0));
endmodule

// File: rtl/pwm_aq_force.sv
module pwm_aq_force
  import pwm_aq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic                    zero_evt,
  input  logic                    prd_evt,
  input  rld_e                    mode,
  input  logic [NUM_CH-1:0][1:0]  shadow,
  output logic [NUM_CH-1:0][1:0]  frc_o
);
  logic                   load;
  logic [NUM_CH-1:0][1:0] active_q;

  always_comb begin
    case (mode)
      RLD_ZERO:   load = tick && zero_evt;
      RLD_PRD:    load = tick && prd_evt;
      RLD_EITHER: load = tick && (zero_evt || prd_evt);
      default:    load = tick;
    endcase
  end

  // The copied value governs the level on the reload tick itself
  assign frc_o = load ? shadow : active_q;

  always_ff @(posedge clk) begin
    if (rst) active_q <= '0;
    else if (load) active_q <= shadow;
  end

  // R2: no tick, no change of the active force
  p_force_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(active_q));

  // R7: zero-reload mode ignores ticks without the zero strobe
  p_zero_only_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == RLD_ZERO && !zero_evt) |=> $stable(active_q));

  // R7: immediate mode copies the shadow on any tick
  p_now_load_r7: assert property (@(posedge clk) disable iff (rst)
    (tick && mode == RLD_NOW) |=> (active_q == $past(shadow)));
endmodule

// File: rtl/pwm_aq_chan.sv
module pwm_aq_chan
  import pwm_aq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     ev_zero,
  input  logic     ev_prd,
  input  logic     ev_ca,
  input  logic     ev_cb,
  input  act_set_t act,
  input  logic [1:0] frc,
  output logic     out
);
  act_e sel;
  logic nxt;
  logic frc_free;

  // Later assignments win: compare B > compare A > period > zero
  always_comb begin
    sel = ACT_NONE;
    if (ev_zero && act.zro != ACT_NONE) sel = act.zro;
    if (ev_prd  && act.prd != ACT_NONE) sel = act.prd;
    if (ev_ca   && act.ca  != ACT_NONE) sel = act.ca;
    if (ev_cb   && act.cb  != ACT_NONE) sel = act.cb;
  end

  assign frc_free = (frc_e'(frc) != FRC_LOW) && (frc_e'(frc) != FRC_HIGH);

  always_comb begin
    case (sel)
      ACT_LOW:  nxt = 1'b0;
      ACT_HIGH: nxt = 1'b1;
      ACT_TOG:  nxt = ~out;
      default:  nxt = out;
    endcase
    if (frc_e'(frc) == FRC_LOW)  nxt = 1'b0;
    if (frc_e'(frc) == FRC_HIGH) nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) out <= 1'b0;
    else if (tick) out <= nxt;
  end

  // R1: output low right after reset
  p_reset_low_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out);

  // R2: output holds between ticks
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(out));

  // R6: forced low / high win over any event
  p_force_low_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && frc_e'(frc) == FRC_LOW) |=> !out);
  p_force_high_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && frc_e'(frc) == FRC_HIGH) |=> out);

  // R3: a lone toggle-coded zero event inverts the level
  p_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && frc_free && ev_zero && !ev_prd && !ev_ca && !ev_cb && act.zro == ACT_TOG)
    |=> (out != $past(out)));
endmodule

// File: rtl/pwm_aq.sv
module pwm_aq
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              cnt_up,
  input  logic              zero_evt,
  input  logic              prd_evt,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_a,
  output logic              pwm_b
);
  logic [NUM_CH-1:0][CNT_W-1:0] cmp;
  act_set_t [NUM_CH-1:0]        act;
  logic [NUM_CH-1:0][1:0]       frc_sh;
  logic [NUM_CH-1:0][1:0]       frc;
  rld_e                         rld;
  logic [NUM_CH-1:0]            hit;
  logic [NUM_CH-1:0]            out;

  pwm_aq_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cmp_o    (cmp),
    .act_o    (act),
    .frc_sh_o (frc_sh),
    .rld_o    (rld)
  );

  pwm_aq_force u_force (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .zero_evt (zero_evt),
    .prd_evt  (prd_evt),
    .mode     (rld),
    .shadow   (frc_sh),
    .frc_o    (frc)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign hit[k] = cnt_up && (cnt == cmp[k]);

    pwm_aq_chan u_chan (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .ev_zero (zero_evt),
      .ev_prd  (prd_evt),
      .ev_ca   (hit[0]),
      .ev_cb   (hit[1]),
      .act     (act[k]),
      .frc     (frc[k]),
      .out     (out[k])
    );
  end

  assign pwm_a = out[0];
  assign pwm_b = out[1];

  // R4: a down-counting tick with no zero/period strobe and no force changes nothing
  p_down_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_up && !zero_evt && !prd_evt && frc[0][0] == frc[0][1] && frc[1][0] == frc[1][1])
    |=> ($stable(pwm_a) && $stable(pwm_b)));
endmodule

// File: tb/pwm_aq_tb.sv
module pwm_aq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        tick;
  logic [15:0] cnt;
  logic        cnt_up;
  logic        zero_evt;
  logic        prd_evt;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic        pwm_a;
  logic        pwm_b;

  int n_total = 0;
  int n_fail  = 0;

  // Reference state, built from what the bench writes
  logic [15:0] m_cmp [2];
  logic [9:0]  m_act [2];
  logic [3:0]  m_sh;
  logic [1:0]  m_rld;
  logic [3:0]  m_af;
  logic        m_out [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_aq u_dut (
    .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .cnt_up(cnt_up),
    .zero_evt(zero_evt), .prd_evt(prd_evt), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  task automatic chk(input logic act_v, input logic exp_v, input string tag, input string what);
    n_total++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act_v, exp_v, $time);
    end
  endtask

  function automatic logic apply_code(input logic cur, input logic [1:0] code);
    case (code)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return !cur;
      default: return cur;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_cmp[i] = '0; m_act[i] = '0; m_out[i] = 1'b0;
    end
    m_sh = '0; m_rld = '0; m_af = '0;
  endtask

  task automatic idle_inputs();
    tick = 0; cnt = '0; cnt_up = 1; zero_evt = 0; prd_evt = 0;
    wr_en = 0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst = 1;
    tick = 1; zero_evt = 1; prd_evt = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    idle_inputs();
    model_reset();
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    idle_inputs();
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk);
    case (a)
      3'd0: m_cmp[0] = d;
      3'd1: m_cmp[1] = d;
      3'd2: m_act[0] = d[9:0];
      3'd3: m_act[1] = d[9:0];
      3'd4: m_sh     = d[3:0];
      3'd5: m_rld    = d[7:6];
      default: ;
    endcase
    #1;
    wr_en = 0;
  endtask

  task automatic step(input logic tk, input logic [15:0] c, input logic z,
                      input logic p, input logic u, input string tag);
    logic ld;
    logic ev_ca, ev_cb;
    logic [1:0] code, f;
    @(negedge clk);
    idle_inputs();
    tick = tk; cnt = c; zero_evt = z; prd_evt = p; cnt_up = u;
    @(posedge clk);
    if (tk) begin
      ld = (m_rld == 2'd3) || (m_rld == 2'd0 && z) || (m_rld == 2'd1 && p) ||
           (m_rld == 2'd2 && (z || p));
      if (ld) m_af = m_sh;
      ev_ca = u && (c == m_cmp[0]);
      ev_cb = u && (c == m_cmp[1]);
      for (int ch = 0; ch < 2; ch++) begin
        if (ev_cb && m_act[ch][9:8] != 2'b00)      code = m_act[ch][9:8];
        else if (ev_ca && m_act[ch][5:4] != 2'b00) code = m_act[ch][5:4];
        else if (p && m_act[ch][3:2] != 2'b00)     code = m_act[ch][3:2];
        else if (z && m_act[ch][1:0] != 2'b00)     code = m_act[ch][1:0];
        else                                       code = 2'b00;
        m_out[ch] = apply_code(m_out[ch], code);
        f = m_af[2*ch +: 2];
        if (f == 2'b01) m_out[ch] = 1'b0;
        if (f == 2'b10) m_out[ch] = 1'b1;
      end
    end
    #1;
    chk(pwm_a, m_out[0], tag, "pwm_a");
    chk(pwm_b, m_out[1], tag, "pwm_b");
  endtask

  function automatic logic [15:0] spread(input logic [7:0] c);
    return {6'b0, c[7:6], 2'b00, c[5:4], c[3:2], c[1:0]};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_total++;
    n_fail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    rst = 1;
    idle_inputs();
    model_reset();
    do_reset();

    // R1: outputs low after reset, events with cleared actions do nothing
    #1;
    chk(pwm_a, 1'b0, "R1", "pwm_a after reset");
    chk(pwm_b, 1'b0, "R1", "pwm_b after reset");
    wr(3'd2, 16'h0003);
    wr(3'd3, 16'h0003);
    wr(3'd4, 16'h000A);
    wr(3'd5, 16'h00C0);
    do_reset();
    step(1, 16'd0, 1, 1, 1, "R1");
    step(1, 16'd0, 1, 0, 1, "R1");

    // R3 R4 R5 R2: sweep all action codes with separate and equal compares
    for (int cfg = 0; cfg < 2; cfg++) begin
      wr(3'd0, 16'd2);
      wr(3'd1, (cfg == 0) ? 16'd4 : 16'd2);
      for (int combo = 0; combo < 256; combo++) begin
        wr(3'd2, spread(combo[7:0]));
        wr(3'd3, spread(combo[7:0] ^ 8'hA5));
        for (int zp = 0; zp < 4; zp++) begin
          for (int ci = 0; ci < 3; ci++) begin
            for (int u = 1; u >= 0; u--) begin
              logic [15:0] cv;
              int nev;
              string tg;
              cv = (ci == 0) ? 16'd1 : (ci == 1) ? 16'd2 : 16'd4;
              nev = zp[0] + zp[1] + ((u == 1 && cv == m_cmp[0]) ? 1 : 0) +
                    ((u == 1 && cv == m_cmp[1]) ? 1 : 0);
              if (nev > 1) tg = "R5";
              else if (u == 0) tg = "R4";
              else tg = "R3";
              step(1, cv, zp[0], zp[1], u[0], tg);
            end
          end
        end
        step(0, 16'd2, 1, 1, 1, "R2");
      end
    end

    // R9: normal polarity on A, inverted on B
    do_reset();
    wr(3'd0, 16'd2);
    wr(3'd1, 16'd3);
    wr(3'd2, 16'h001A);
    wr(3'd3, 16'h0205);
    for (int per = 0; per < 2; per++) begin
      for (int c = 0; c <= 4; c++) begin
        step(1, c[15:0], c == 0, c == 4, 1, "R9");
      end
    end
    // explicit level inside a period: after compare A, A low; B high after compare B
    step(1, 16'd0, 1, 0, 1, "R9");
    chk(pwm_a, 1'b1, "R9", "normal high after zero");
    chk(pwm_b, 1'b0, "R9", "inverted low after zero");
    step(1, 16'd3, 0, 0, 1, "R9");
    chk(pwm_a, 1'b1, "R9", "compare A not at 3");
    chk(pwm_b, 1'b1, "R9", "inverted high at compare B");

    // R10: moving compare A moves the edge
    wr(3'd0, 16'd1);
    for (int c = 0; c <= 4; c++) begin
      step(1, c[15:0], c == 0, c == 4, 1, "R10");
    end

    // R8 then R7: shadow write held until zero reload
    do_reset();
    wr(3'd4, 16'h0002);
    step(1, 16'd5, 0, 1, 1, "R8");
    chk(pwm_a, 1'b0, "R8", "shadow not yet active");
    step(1, 16'd0, 1, 0, 1, "R7");
    chk(pwm_a, 1'b1, "R7", "force high at zero reload");

    // R11: releasing the force lets the same-tick action act
    wr(3'd0, 16'd2);
    wr(3'd2, 16'h001A);
    wr(3'd5, 16'h00C0);
    wr(3'd4, 16'h0000);
    step(1, 16'd2, 0, 0, 1, "R11");
    chk(pwm_a, 1'b0, "R11", "compare A low on release tick");

    // R6 R7: every shadow code under every reload mode with events coinciding
    do_reset();
    wr(3'd0, 16'd2);
    wr(3'd1, 16'd3);
    wr(3'd2, 16'h001A);
    wr(3'd3, 16'h0205);
    for (int mode = 0; mode < 4; mode++) begin
      wr(3'd5, 16'(mode << 6));
      for (int sh = 0; sh < 16; sh++) begin
        wr(3'd4, 16'(sh));
        for (int c = 0; c <= 4; c++) begin
          string tg;
          tg = (m_af != 4'h0) ? "R6" : "R7";
          step(1, c[15:0], c == 0, c == 4, 1, tg);
        end
        step(0, 16'd0, 1, 1, 1, "R2");
      end
    end

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule